// File: doc/BRIEF.md
# Host-Window Dual-Port Memory Bridge

This block lets a narrow host bus and a wide accelerator share one buffer memory. On the host side there is an 8-bit I/O bus and a 20-bit, byte-addressed memory bus. One I/O port holds a control byte. That byte opens the shared buffer as a linear window in host memory space, picks where the window sits, and holds the accelerator in or out of reset. On the accelerator side the same buffer appears as a run of 64-bit words at a fixed base address.

The buffer is packed to match the accelerator's interface width, which is set by the build parameter `PACK_BYTES` (1, 2 or 4). Consecutive host bytes fill the low byte lanes of one 64-bit word, lowest address in lane 0. The rest of each word is empty. The host window is therefore 1 KB, 2 KB or 4 KB long, while the accelerator-side span always covers `WORD_DEPTH` words. Both sides read with one cycle of latency. When both ports write the same byte in the same cycle, the accelerator's data is kept.

Top module: `dpw_bridge`

## Requirements
- R1: Only an I/O write whose address equals `LATCH_PORT` (default 0x300) loads the control byte. Writes to any other I/O address leave the control byte, and so `acc_rst` and the window, unchanged.
- R2: After `rst` the control byte acts as 0x40. `acc_rst` is 1, the window is closed, host reads return 0 and host writes are dropped.
- R3: Bit 6 of the control byte drives `acc_rst` (1 = accelerator held in reset). `acc_rst` takes the written value on the clock edge that loads the byte.
- R4: Bit 7 of the control byte opens the window and bits 2:0 select a slot. The window starts at host address 0xD8000 + slot × 0x2000, so byte 0xC2 opens it at 0xDC000. It is `WORD_DEPTH`×`PACK_BYTES` bytes long.
- R5: A host memory read or write outside the window, or made while bit 7 is clear, leaves the buffer untouched. Such a read returns 0 on `mem_rdata` one cycle later.
- R6: Host byte at window offset o maps to word o / `PACK_BYTES`, lane o mod `PACK_BYTES`. Lane n is `acc_wdata`/`acc_rdata` bits 8n+7:8n, in little-endian order with no swap. A host read returns the byte on `mem_rdata` the cycle after `mem_rd`.
- R7: The accelerator span starts at 0xC0000000 when `PACK_BYTES`=1 and at 0xD0040000 otherwise, and covers `WORD_DEPTH`×8 bytes (word index = address bits above bit 2). Accelerator reads outside it return 0 and writes outside it are dropped.
- R8: Accelerator writes honour `acc_be` per lane. Lanes at or above `PACK_BYTES` are never stored, and they always read as 0.
- R9: When the host and the accelerator write the same byte in the same cycle, the accelerator's value is stored. Writes to different lanes of one word in the same cycle both land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Host I/O write strobe |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host I/O write data |
| mem_rd | input | 1 | Host memory read strobe |
| mem_wr | input | 1 | Host memory write strobe |
| mem_addr | input | 20 | Host memory byte address |
| mem_wdata | input | 8 | Host memory write data |
| mem_rdata | output | 8 | Host read data, one cycle after `mem_rd` |
| acc_en | input | 1 | Accelerator access strobe |
| acc_we | input | 1 | Accelerator write (1) or read (0) |
| acc_addr | input | 32 | Accelerator byte address, 64-bit aligned |
| acc_be | input | 8 | Accelerator byte-lane enables |
| acc_wdata | input | 64 | Accelerator write data |
| acc_rdata | output | 64 | Accelerator read data, one cycle after `acc_en` |
| acc_rst | output | 1 | Accelerator reset, from the control byte |

## Verification
The bench fills the complete host window with an arithmetic byte sequence. It then reads every accelerator word and compares each lane against the offset-derived byte. This catches swapped lanes, a wrong word stride and missing zero lanes in one pass. A second pass runs the other way: the accelerator writes every word with all byte enables set and the host reads every byte back. That pass shows that the upper lanes are discarded and that the lane order is little-endian.

Targeted accesses probe specific edges. They hit one byte past the window end, one byte below the base, a different slot, a closed window, an accelerator address one span too high and the base of the other packing variant. After each, the bench reads a word that would alias if an address bit were truncated. Same-cycle writes from both ports separate the case where the two writes collide on one byte from the case where they share a word but use different lanes.

// File: rtl/dpw_pkg.sv
package dpw_pkg;

  localparam int HOST_AW = 20;
  localparam int IO_AW   = 16;
  localparam int ACC_AW  = 32;
  localparam int ACC_DW  = 64;
  localparam int LANES   = ACC_DW / 8;

  localparam logic [HOST_AW-1:0] HOST_SLOT0 = 20'hD8000;

  typedef struct packed {
    logic       win_en;
    logic       acc_hold;
    logic [2:0] slot;
  } dpw_ctl_t;

  function automatic logic [HOST_AW-1:0] host_window_base(input logic [2:0] slot);
    return HOST_SLOT0 + {4'd0, slot, 13'd0};
  endfunction

  function automatic logic [ACC_AW-1:0] acc_window_base(input int pack);
    return (pack == 1) ? 32'hC000_0000 : 32'hD004_0000;
  endfunction

endpackage

// File: rtl/dpw_ctrl_latch.sv
module dpw_ctrl_latch
  import dpw_pkg::*;
#(
  parameter logic [IO_AW-1:0] LATCH_PORT = 16'h0300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_wr,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [7:0]       io_wdata,
  output dpw_ctl_t         ctl
);

  logic port_hit;
  assign port_hit = io_wr && (io_addr == LATCH_PORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl.win_en   <= 1'b0;
      ctl.acc_hold <= 1'b1;
      ctl.slot     <= 3'd0;
    end else if (port_hit) begin
      ctl.win_en   <= io_wdata[7];
      ctl.acc_hold <= io_wdata[6];
      ctl.slot     <= io_wdata[2:0];
    end
  end

  logic unused_ctl_bits;
  assign unused_ctl_bits = ^io_wdata[5:3];

endmodule

// File: rtl/dpw_lane_ram.sv
module dpw_lane_ram #(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_idx,
  input  logic [7:0]    a_d,
  output logic [7:0]    a_q,
  input  logic          b_we,
  input  logic [AW-1:0] b_idx,
  input  logic [7:0]    b_d,
  output logic [7:0]    b_q
);

  logic [7:0] mem [DEPTH];

  // Port b is written last, so on an index collision its byte is kept.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_idx] <= a_d;
    if (b_we) mem[b_idx] <= b_d;
    a_q <= mem[a_idx];
    b_q <= mem[b_idx];
  end

endmodule

// File: rtl/dpw_host_side.sv
module dpw_host_side
  import dpw_pkg::*;
#(
  parameter int PACK    = 2,
  parameter int DEPTH   = 1024,
  parameter int WORD_AW = $clog2(DEPTH),
  parameter int LANE_W  = (PACK > 1) ? $clog2(PACK) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  dpw_ctl_t               ctl,
  input  logic                   mem_rd,
  input  logic                   mem_wr,
  input  logic [HOST_AW-1:0]     mem_addr,
  input  logic [7:0]             mem_wdata,
  input  logic [PACK-1:0][7:0]   lane_q,
  output logic [PACK-1:0]        lane_we,
  output logic [WORD_AW-1:0]     word_idx,
  output logic [7:0]             wr_byte,
  output logic [7:0]             mem_rdata
);

  localparam int WIN_BYTES = DEPTH * PACK;

  logic [HOST_AW-1:0] off;
  logic               hit;
  logic [LANE_W-1:0]  lane;
  logic               rd_hit_q;
  logic [LANE_W-1:0]  rd_lane_q;

  assign off      = mem_addr - host_window_base(ctl.slot);
  assign hit      = ctl.win_en && (off < HOST_AW'(WIN_BYTES));
  assign lane     = LANE_W'(off % PACK);
  assign word_idx = WORD_AW'(off / PACK);
  assign wr_byte  = mem_wdata;

  for (genvar l = 0; l < PACK; l++) begin : g_we
    assign lane_we[l] = mem_wr && hit && (lane == LANE_W'(l));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hit_q  <= 1'b0;
      rd_lane_q <= '0;
    end else begin
      rd_hit_q  <= mem_rd && hit;
      rd_lane_q <= lane;
    end
  end

  assign mem_rdata = rd_hit_q ? lane_q[rd_lane_q] : 8'd0;

endmodule

// File: rtl/dpw_acc_side.sv
module dpw_acc_side
  import dpw_pkg::*;
#(
  parameter int                PACK     = 2,
  parameter int                DEPTH    = 1024,
  parameter int                WORD_AW  = $clog2(DEPTH),
  parameter logic [ACC_AW-1:0] ACC_BASE = 32'hD004_0000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_en,
  input  logic                  acc_we,
  input  logic [ACC_AW-1:0]     acc_addr,
  input  logic [LANES-1:0]      acc_be,
  input  logic [ACC_DW-1:0]     acc_wdata,
  input  logic [PACK-1:0][7:0]  lane_q,
  output logic [PACK-1:0]       lane_we,
  output logic [WORD_AW-1:0]    word_idx,
  output logic [PACK-1:0][7:0]  wr_bytes,
  output logic [ACC_DW-1:0]     acc_rdata
);

  localparam int SPAN_BYTES = DEPTH * LANES;

  logic [ACC_AW-1:0] off;
  logic              hit;
  logic              rd_hit_q;

  assign off      = acc_addr - ACC_BASE;
  assign hit      = off < ACC_AW'(SPAN_BYTES);
  assign word_idx = WORD_AW'(off >> 3);

  for (genvar l = 0; l < PACK; l++) begin : g_lane
    assign lane_we[l]  = acc_en && acc_we && hit && acc_be[l];
    assign wr_bytes[l] = acc_wdata[8*l +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_hit_q <= 1'b0;
    else     rd_hit_q <= acc_en && !acc_we && hit;
  end

  assign acc_rdata = rd_hit_q ? ACC_DW'(lane_q) : '0;

  logic unused_upper_lanes;
  assign unused_upper_lanes = ^{acc_be[LANES-1:PACK], acc_wdata[ACC_DW-1:8*PACK]};

endmodule

// File: rtl/dpw_bridge.sv
module dpw_bridge
  import dpw_pkg::*;
#(
  parameter int                PACK_BYTES = 2,
  parameter int                WORD_DEPTH = 1024,
  parameter logic [IO_AW-1:0]  LATCH_PORT = 16'h0300
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                io_wr,
  input  logic [IO_AW-1:0]    io_addr,
  input  logic [7:0]          io_wdata,
  input  logic                mem_rd,
  input  logic                mem_wr,
  input  logic [HOST_AW-1:0]  mem_addr,
  input  logic [7:0]          mem_wdata,
  output logic [7:0]          mem_rdata,
  input  logic                acc_en,
  input  logic                acc_we,
  input  logic [ACC_AW-1:0]   acc_addr,
  input  logic [LANES-1:0]    acc_be,
  input  logic [ACC_DW-1:0]   acc_wdata,
  output logic [ACC_DW-1:0]   acc_rdata,
  output logic                acc_rst
);

  localparam int                WORD_AW  = $clog2(WORD_DEPTH);
  localparam logic [ACC_AW-1:0] ACC_BASE = acc_window_base(PACK_BYTES);

  dpw_ctl_t ctl;

  logic [PACK_BYTES-1:0]      h_we;
  logic [WORD_AW-1:0]         h_idx;
  logic [7:0]                 h_byte;
  logic [PACK_BYTES-1:0][7:0] h_q;

  logic [PACK_BYTES-1:0]      a_we;
  logic [WORD_AW-1:0]         a_idx;
  logic [PACK_BYTES-1:0][7:0] a_bytes;
  logic [PACK_BYTES-1:0][7:0] a_q;

  dpw_ctrl_latch #(.LATCH_PORT(LATCH_PORT)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .io_wr    (io_wr),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .ctl      (ctl)
  );

  dpw_host_side #(.PACK(PACK_BYTES), .DEPTH(WORD_DEPTH), .WORD_AW(WORD_AW)) u_host (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .lane_q    (h_q),
    .lane_we   (h_we),
    .word_idx  (h_idx),
    .wr_byte   (h_byte),
    .mem_rdata (mem_rdata)
  );

  dpw_acc_side #(.PACK(PACK_BYTES), .DEPTH(WORD_DEPTH), .WORD_AW(WORD_AW),
                 .ACC_BASE(ACC_BASE)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .acc_en    (acc_en),
    .acc_we    (acc_we),
    .acc_addr  (acc_addr),
    .acc_be    (acc_be),
    .acc_wdata (acc_wdata),
    .lane_q    (a_q),
    .lane_we   (a_we),
    .word_idx  (a_idx),
    .wr_bytes  (a_bytes),
    .acc_rdata (acc_rdata)
  );

  for (genvar l = 0; l < PACK_BYTES; l++) begin : g_ram
    dpw_lane_ram #(.DEPTH(WORD_DEPTH), .AW(WORD_AW)) u_ram (
      .clk   (clk),
      .a_we  (h_we[l]),
      .a_idx (h_idx),
      .a_d   (h_byte),
      .a_q   (h_q[l]),
      .b_we  (a_we[l]),
      .b_idx (a_idx),
      .b_d   (a_bytes[l]),
      .b_q   (a_q[l])
    );
  end

  assign acc_rst = ctl.acc_hold;

endmodule

// File: rtl/dpw_bridge_chk.sv
module dpw_bridge_chk
  import dpw_pkg::*;
#(
  parameter int               PACK_BYTES = 2,
  parameter int               WORD_DEPTH = 1024,
  parameter logic [IO_AW-1:0] LATCH_PORT = 16'h0300
) (
  input logic               clk,
  input logic               rst,
  input logic               io_wr,
  input logic [IO_AW-1:0]   io_addr,
  input logic [7:0]         io_wdata,
  input logic               mem_rd,
  input logic [HOST_AW-1:0] mem_addr,
  input logic [7:0]         mem_rdata,
  input logic               acc_en,
  input logic [ACC_AW-1:0]  acc_addr,
  input logic [ACC_DW-1:0]  acc_rdata,
  input logic               acc_rst
);

  localparam logic [ACC_AW-1:0] CHK_BASE = acc_window_base(PACK_BYTES);
  localparam logic [ACC_AW-1:0] CHK_SPAN = ACC_AW'(WORD_DEPTH * LANES);

  logic acc_outside;
  assign acc_outside = (acc_addr - CHK_BASE) >= CHK_SPAN;

  AST_RESET_HOLDS_ACC: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> acc_rst);  // R2

  AST_LATCH_DRIVES_RST: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == LATCH_PORT) |=> (acc_rst == $past(io_wdata[6])));  // R3

  AST_OTHER_PORT_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr != LATCH_PORT) |=> $stable(acc_rst));  // R1

  AST_HOST_BELOW_SLOTS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_addr < HOST_SLOT0) |=> (mem_rdata == 8'd0));  // R5

  AST_ACC_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc_en && acc_outside) |=> (acc_rdata == '0));  // R7

  AST_UNUSED_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc_rdata >> (8 * PACK_BYTES)) == '0);  // R8

endmodule

bind dpw_bridge dpw_bridge_chk #(
  .PACK_BYTES (PACK_BYTES),
  .WORD_DEPTH (WORD_DEPTH),
  .LATCH_PORT (LATCH_PORT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .io_wr     (io_wr),
  .io_addr   (io_addr),
  .io_wdata  (io_wdata),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr),
  .mem_rdata (mem_rdata),
  .acc_en    (acc_en),
  .acc_addr  (acc_addr),
  .acc_rdata (acc_rdata),
  .acc_rst   (acc_rst)
);

// File: tb/dpw_bridge_bench.sv
`timescale 1ns/1ps
module dpw_bridge_bench;

  localparam int PACK  = 2;
  localparam int DEPTH = 1024;
  localparam int WIN   = PACK * DEPTH;
  localparam logic [19:0] HBASE = 20'hDC000;
  localparam logic [31:0] ABASE = 32'hD004_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0;
  logic [19:0] mem_addr = '0;
  logic [7:0]  mem_wdata = '0;
  logic [7:0]  mem_rdata;
  logic        acc_en = 1'b0, acc_we = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [7:0]  acc_be = '0;
  logic [63:0] acc_wdata = '0;
  logic [63:0] acc_rdata;
  logic        acc_rst;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dpw_bridge u_dpw_bridge (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_be(acc_be), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .acc_rst(acc_rst)
  );

  function automatic logic [7:0] pat(input int o);
    return 8'((o * 37 + 11) ^ (o >> 5));
  endfunction

  function automatic logic [15:0] apat(input int k);
    return 16'((k * 257) ^ 16'h5AA5);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic host_wr(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk); mem_wr = 1'b1; mem_addr = a; mem_wdata = d;
    @(negedge clk); mem_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [19:0] a, output logic [7:0] d);
    @(negedge clk); mem_rd = 1'b1; mem_addr = a;
    @(negedge clk); mem_rd = 1'b0; d = mem_rdata;
  endtask

  task automatic acc_wr(input logic [31:0] a, input logic [7:0] be, input logic [63:0] d);
    @(negedge clk); acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_be = be; acc_wdata = d;
    @(negedge clk); acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic acc_rd(input logic [31:0] a, output logic [63:0] d);
    @(negedge clk); acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
    @(negedge clk); acc_en = 1'b0; d = acc_rdata;
  endtask

  function automatic logic [63:0] word_of_pat(input int k);
    return {48'd0, pat(2*k+1), pat(2*k)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [63:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2: reset state
    chk("R2 acc_rst after reset", 64'(acc_rst), 64'd1);
    host_rd(20'hD8000, b);
    chk("R2 closed window read", 64'(b), 64'd0);

    // R1: other I/O port ignored
    io_write(16'h0301, 8'h00);
    chk("R1 other port acc_rst", 64'(acc_rst), 64'd1);
    host_rd(20'hD8000, b);
    chk("R1 other port window still closed", 64'(b), 64'd0);

    // R3: latch drives reset
    io_write(16'h0300, 8'hC2);
    chk("R3 acc_rst after 0xC2", 64'(acc_rst), 64'd1);
    io_write(16'h0300, 8'h82);
    chk("R3 acc_rst after 0x82", 64'(acc_rst), 64'd0);

    // R6: host fill, accelerator sweep
    for (int o = 0; o < WIN; o++) host_wr(HBASE + 20'(o), pat(o));
    for (int k = 0; k < DEPTH; k++) begin
      acc_rd(ABASE + 32'(8*k), w);
      chk("R6 host-to-acc lane map", w, word_of_pat(k));
    end

    // R5: closed window leaves buffer untouched
    io_write(16'h0300, 8'h02);
    host_wr(HBASE, 8'h5A);
    host_rd(HBASE, b);
    chk("R5 closed window read zero", 64'(b), 64'd0);
    acc_rd(ABASE, w);
    chk("R5 closed window write dropped", w, word_of_pat(0));
    io_write(16'h0300, 8'h82);

    // R4/R5: just past end and just below base
    host_wr(HBASE + 20'(WIN), 8'hEE);
    host_rd(HBASE + 20'(WIN), b);
    chk("R4 past end reads zero", 64'(b), 64'd0);
    acc_rd(ABASE, w);
    chk("R5 past end no alias write", w, word_of_pat(0));
    host_wr(HBASE - 20'd1, 8'hEE);
    acc_rd(ABASE + 32'(8*(DEPTH-1)), w);
    chk("R5 below base no write", w, word_of_pat(DEPTH-1));

    // R4: slot selection
    io_write(16'h0300, 8'h80);
    host_rd(20'hD8005, b);
    chk("R4 slot0 base", 64'(b), 64'(pat(5)));
    host_rd(20'hDC005, b);
    chk("R4 old slot closed", 64'(b), 64'd0);
    io_write(16'h0300, 8'h82);
    host_rd(HBASE + 20'(WIN-1), b);
    chk("R4 last byte of slot2", 64'(b), 64'(pat(WIN-1)));

    // R7: accelerator span
    acc_rd(ABASE + 32'(8*DEPTH), w);
    chk("R7 read past span", w, 64'd0);
    acc_wr(ABASE + 32'(8*DEPTH), 8'hFF, '1);
    acc_rd(ABASE, w);
    chk("R7 write past span dropped", w, word_of_pat(0));
    acc_rd(32'hC000_0000, w);
    chk("R7 other variant base", w, 64'd0);

    // R8: lanes and byte enables
    acc_wr(ABASE + 32'(8*10), 8'hFF, 64'h1122334455667788);
    acc_rd(ABASE + 32'(8*10), w);
    chk("R8 upper lanes dropped", w, 64'h7788);
    host_rd(HBASE + 20'd20, b);
    chk("R6 lane0 little-endian", 64'(b), 64'h88);
    host_rd(HBASE + 20'd21, b);
    chk("R6 lane1 little-endian", 64'(b), 64'h77);
    acc_wr(ABASE + 32'(8*10), 8'h02, 64'h0000_0000_0000_AB00);
    acc_rd(ABASE + 32'(8*10), w);
    chk("R8 byte enable lane1 only", w, 64'hAB88);

    // R9: same-cycle writes
    @(negedge clk);
    mem_wr = 1'b1; mem_addr = HBASE + 20'd40; mem_wdata = 8'h11;
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = ABASE + 32'(8*20); acc_be = 8'h01; acc_wdata = 64'h22;
    @(negedge clk);
    mem_wr = 1'b0; acc_en = 1'b0; acc_we = 1'b0;
    host_rd(HBASE + 20'd40, b);
    chk("R9 collision accelerator wins", 64'(b), 64'h22);
    @(negedge clk);
    mem_wr = 1'b1; mem_addr = HBASE + 20'd43; mem_wdata = 8'h33;
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = ABASE + 32'(8*21); acc_be = 8'h01; acc_wdata = 64'h44;
    @(negedge clk);
    mem_wr = 1'b0; acc_en = 1'b0; acc_we = 1'b0;
    acc_rd(ABASE + 32'(8*21), w);
    chk("R9 different lanes both land", w, 64'h3344);

    // R6: accelerator fill, host sweep
    for (int k = 0; k < DEPTH; k++)
      acc_wr(ABASE + 32'(8*k), 8'hFF, {48'hDEAD_BEEF_CAFE, apat(k)});
    for (int o = 0; o < WIN; o++) begin
      host_rd(HBASE + 20'(o), b);
      chk("R6 acc-to-host lane map", 64'(b), 64'(apat(o / 2) >> (8 * (o % 2))) & 64'hFF);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule